// File: doc/BRIEF.md
# Programmable Card Clock Selector

This block makes the clock that is driven to a smart card from a free-running input clock. The card clock can be the input clock itself, or the input clock divided by 2, 4 or 8. It can also be parked at a static high or a static low level. A 3-bit counter runs freely on the input clock, and its bits supply the divided clocks. All registers update on the falling edge of the input clock. This keeps the gated pass-through path clean.

A host writes 4-bit commands. The command field is sampled while the active-low select is held low. The last value sampled is decoded when the select returns high. A command does not change the output at once. It becomes a pending setting, and the active setting copies it only on an edge where the move creates no short pulse. The ratio command also carries a card-supply choice (3 V or 5 V), which is passed out on its own flag. The host interface is assumed to be synchronous to the input clock.

Command codes: `cmd[3]=0` selects a ratio command. In that case `cmd[1:0]` = 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /8, and `cmd[2]` gives the supply flag (1 = 5 V). The other codes are 4'b1000 (stop low), 4'b1001 (stop high) and 4'b1010 (run). Codes 4'b1011 to 4'b1111 are not used.

Top module: `card_clk_sel`

## Requirements
- R1: While reset is asserted and after it is released, `card_clk` is low and `vsel_5v` is 0. The block starts stopped low with the ratio set to /1.
- R2: When running with ratio code 00, `card_clk` follows `clk_in`: it is high while `clk_in` is high and low while `clk_in` is low.
- R3: When running with ratio code 01, 10 or 11, `card_clk` has a period of 2, 4 or 8 input cycles with equal high and low phases.
- R4: Command 4'b1001 holds `card_clk` static high and command 4'b1000 holds it static low, whatever the ratio is.
- R5: Command 4'b1010 restarts the clock after a stop, at the ratio programmed most recently, including a ratio written while stopped.
- R6: `vsel_5v` takes `cmd[2]` of each ratio command when that command is decoded. Stop, run and unused codes leave it unchanged.
- R7: A command acts only on a low-to-high transition of `cs_n`, and the value that acts is the last `cmd` sampled while `cs_n` was low. Changes of `cmd` while `cs_n` is high have no effect.
- R8: A change that leaves a divided running setting is applied only on an edge where the output keeps its level. Every high or low phase across a change between /4 and /8, or into stop, lasts at least two input cycles. A pending change is applied within 8 input cycles.
- R9: Unused codes 4'b1011 to 4'b1111 change neither the running clock nor `vsel_5v`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock. Registers update on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low command select. A rising edge decodes the command |
| cmd | input | 4 | Command field, sampled while `cs_n` is low |
| card_clk | output | 1 | Clock driven to the card |
| vsel_5v | output | 1 | Card supply choice from the last ratio command (1 = 5 V) |

## Verification
A newly decoded command can land in the same cycle in which an earlier pending change is still waiting for its level match. The pending setting is then replaced before, or just after, the earlier change is applied. The bench provokes this by sending stop high and then run back to back while /8 is running. It judges the result by requiring an unbroken /8 waveform afterwards, with no phase shorter than the guard length. A run-length monitor also watches every ratio switch between /4 and /8 for short pulses.

// File: rtl/card_clk_sel.sv
module card_clk_sel (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [3:0] cmd,
  output logic       card_clk,
  output logic       vsel_5v
);
  localparam int CNT_W    = 3;
  localparam int RAT_W    = 2;
  localparam int WAIT_MAX = 1 << CNT_W;
  localparam logic [3:0] OP_STOP_LO = 4'b1000;
  localparam logic [3:0] OP_STOP_HI = 4'b1001;
  localparam logic [3:0] OP_RUN     = 4'b1010;

  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_nxt;
  logic             cs_d;
  logic [3:0]       cmd_hold;
  logic             p_run, p_lvl, a_run, a_lvl;
  logic [RAT_W-1:0] p_ratio, a_ratio;
  logic             lvl_q, lvl_next, p_val, apply;

  function automatic logic tap(input logic [RAT_W-1:0] r, input logic [CNT_W-1:0] c);
    case (r)
      2'd1:    tap = c[0];
      2'd2:    tap = c[1];
      2'd3:    tap = c[2];
      default: tap = 1'b0;
    endcase
  endfunction

  assign div_nxt = div_cnt + 1'b1;

  wire cs_rise = cs_n & ~cs_d;
  wire a_pass  = a_run & (a_ratio == '0);
  wire p_pass  = p_run & (p_ratio == '0);
  wire differ  = {p_run, p_lvl, p_ratio} != {a_run, a_lvl, a_ratio};

  assign p_val = p_run ? tap(p_ratio, div_nxt) : p_lvl;
  assign apply = differ & ((~p_run & (~a_run | a_pass)) | (~a_run & p_pass) | (p_val == lvl_q));

  always_comb begin
    if (apply)      lvl_next = p_val;
    else if (!a_run) lvl_next = a_lvl;
    else            lvl_next = tap(a_ratio, div_nxt);
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      cs_d     <= 1'b1;
      cmd_hold <= '0;
      p_run    <= 1'b0;
      p_lvl    <= 1'b0;
      p_ratio  <= '0;
      vsel_5v  <= 1'b0;
    end else begin
      div_cnt <= div_nxt;
      cs_d    <= cs_n;
      if (!cs_n) cmd_hold <= cmd;
      if (cs_rise) begin
        if (!cmd_hold[3]) begin
          p_ratio <= cmd_hold[RAT_W-1:0];
          vsel_5v <= cmd_hold[2];
        end else begin
          case (cmd_hold)
            OP_STOP_LO: begin p_run <= 1'b0; p_lvl <= 1'b0; end
            OP_STOP_HI: begin p_run <= 1'b0; p_lvl <= 1'b1; end
            OP_RUN:     p_run <= 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      a_run   <= 1'b0;
      a_lvl   <= 1'b0;
      a_ratio <= '0;
      lvl_q   <= 1'b0;
    end else begin
      lvl_q <= lvl_next;
      if (apply) begin
        a_run   <= p_run;
        a_lvl   <= p_lvl;
        a_ratio <= p_ratio;
      end
    end
  end

  assign card_clk = a_pass ? clk_in : lvl_q;

  logic [3:0] wait_cnt;
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)                      wait_cnt <= '0;
    else if (!differ || apply || cs_rise) wait_cnt <= '0;
    else if (wait_cnt != 4'hF)       wait_cnt <= wait_cnt + 1'b1;
  end

  AST_STOP_STATIC: assert property (@(negedge clk_in) disable iff (!rst_n)
    !a_run |-> (lvl_q == a_lvl)); // R4
  AST_PASS_LOW_REG: assert property (@(negedge clk_in) disable iff (!rst_n)
    a_pass |-> !lvl_q); // R2
  AST_NO_STEP_ON_SWITCH: assert property (@(negedge clk_in) disable iff (!rst_n)
    ($past(a_run) && !$past(a_pass) && !$stable({a_run, a_lvl, a_ratio})) |-> $stable(lvl_q)); // R8
  AST_SETTLE_BOUND: assert property (@(negedge clk_in) disable iff (!rst_n)
    wait_cnt < 4'(WAIT_MAX + 1)); // R8
  AST_VSEL_ON_SELECT: assert property (@(negedge clk_in) disable iff (!rst_n)
    !$stable(vsel_5v) |-> $past(cs_rise)); // R6
  AST_CMD_GATED: assert property (@(negedge clk_in) disable iff (!rst_n)
    (cs_n && cs_d) |=> $stable({p_run, p_lvl, p_ratio})); // R7
endmodule

// File: tb/card_clk_sel_tb.sv
module card_clk_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic [3:0] cmd = 4'h0;
  logic card_clk, vsel_5v;
  int checks = 0;
  int errors = 0;

  logic mon_en = 1'b0;
  logic mon_first;
  int   mon_min = 1;
  int   mon_run;
  logic mon_last;

  always #5 clk = ~clk;

  card_clk_sel u_dut (
    .clk_in(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd),
    .card_clk(card_clk), .vsel_5v(vsel_5v)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!mon_en) begin
      mon_first = 1'b1;
      mon_run   = 0;
      mon_last  = card_clk;
    end else if (card_clk == mon_last) begin
      mon_run++;
    end else begin
      if (!mon_first) check(mon_run >= mon_min, "R8 phase length", mon_run, mon_min);
      mon_first = 1'b0;
      mon_run   = 1;
      mon_last  = card_clk;
    end
  end

  task automatic send(input logic [3:0] c);
    @(posedge clk); #1; cs_n = 1'b0; cmd = c;
    @(posedge clk); #1; cs_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_static(input logic v, input string req);
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      if (card_clk !== v) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic expect_div(input int h, input string req);
    logic s [64];
    int k = 0;
    int bad = 0;
    wait_cyc(12);
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      s[i] = card_clk;
    end
    for (int i = 1; i < 64 && k == 0; i++) if (s[i] != s[i-1]) k = i;
    if (k == 0 || k > h) bad = 1;
    else for (int i = k; i < 64; i++) if (s[i] != (s[k] ^ logic'(((i - k) / h) % 2))) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic expect_pass(input string req);
    int bad = 0;
    wait_cyc(4);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      if (card_clk !== 1'b1) bad++;
      @(negedge clk); #2;
      if (card_clk !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    #1;
    check(card_clk === 1'b0, "R1 clk in reset", card_clk, 0);
    check(vsel_5v === 1'b0, "R1 vsel in reset", vsel_5v, 0);
    wait_cyc(3); #1; rst_n = 1'b1;
    expect_static(1'b0, "R1 stopped low after reset");
  endtask

  task automatic t_select_gate;
    @(posedge clk); #1; cmd = 4'b1010;
    wait_cyc(4); #1; cmd = 4'b1001;
    wait_cyc(4);
    expect_static(1'b0, "R7 cmd ignored while cs_n high");
    @(posedge clk); #1; cs_n = 1'b0; cmd = 4'b1001;
    @(posedge clk); #1; cmd = 4'b0001;
    @(posedge clk); #1; cs_n = 1'b1;
    wait_cyc(4);
    expect_static(1'b0, "R7 only last sampled cmd acts");
    send(4'b1010);
    expect_div(1, "R7 latched ratio /2 runs");
  endtask

  task automatic t_divide;
    send(4'b0010); expect_div(2, "R3 divide by 4");
    send(4'b0011); expect_div(4, "R3 divide by 8");
    send(4'b0001); expect_div(1, "R3 divide by 2");
  endtask

  task automatic t_pass;
    send(4'b0000);
    expect_pass("R2 pass-through");
  endtask

  task automatic t_stop;
    send(4'b1001); wait_cyc(10);
    expect_static(1'b1, "R4 stop high");
    send(4'b1000); wait_cyc(10);
    expect_static(1'b0, "R4 stop low");
    send(4'b0010);
    expect_static(1'b0, "R4 ratio while stopped keeps level");
    send(4'b1010);
    expect_div(2, "R5 restart at new ratio /4");
  endtask

  task automatic t_supply;
    send(4'b0110); #1;
    check(vsel_5v === 1'b1, "R6 vsel set by ratio cmd", vsel_5v, 1);
    send(4'b1001); #1;
    check(vsel_5v === 1'b1, "R6 vsel kept by stop cmd", vsel_5v, 1);
    send(4'b1010);
    expect_div(2, "R5 restart after stop high");
  endtask

  task automatic t_unused;
    send(4'b1100);
    expect_div(2, "R9 unused code keeps /4");
    check(vsel_5v === 1'b1, "R9 unused code keeps vsel", vsel_5v, 1);
    send(4'b1111);
    expect_div(2, "R9 code 1111 keeps /4");
    send(4'b0010); #1;
    check(vsel_5v === 1'b0, "R6 vsel cleared", vsel_5v, 0);
  endtask

  task automatic t_switch;
    mon_min = 2; mon_en = 1'b1;
    for (int n = 0; n < 6; n++) begin
      send(4'b0011); wait_cyc(3 + n);
      send(4'b0010); wait_cyc(5 + n);
    end
    send(4'b0011); wait_cyc(9);
    send(4'b1001); wait_cyc(10);
    mon_en = 1'b0;
    expect_static(1'b1, "R8 stop high reached within bound");
    mon_en = 1'b1;
    send(4'b1010);
    expect_div(4, "R8 restart /8 after switch");
    mon_en = 1'b0;
  endtask

  task automatic t_overlap;
    mon_min = 4; mon_en = 1'b1;
    for (int n = 0; n < 4; n++) begin
      send(4'b1001);
      send(4'b1010);
      wait_cyc(3 + n);
    end
    expect_div(4, "R8 overlapped stop and run");
    mon_en = 1'b0;
  endtask

  initial begin
    t_reset;
    t_select_gate;
    t_divide;
    t_pass;
    t_stop;
    t_supply;
    t_unused;
    t_switch;
    t_overlap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule